// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block is the digital control core of a simultaneous-sampling successive-approximation converter with four result channels. A start strobe arrives asynchronously. It passes through a synchroniser and an edge detector. The detected edge latches a two-bit mode word, which picks the channel set, and a two-bit auxiliary mux choice. All selected channels are held together for the whole conversion. The block then runs one fixed-length slot per channel, in ascending channel order, and keeps an active-low busy flag low for the whole sequence.

In the last cycle of each slot, the block takes an 11-bit two's-complement code from the converter core and stores it in a shadow register. The readable result registers change only on the edge where busy returns high. Until then, software can read the previous results through a small register port. That port has two address lines and active-low select and read strobes. The 12-bit read word carries the code in its upper eleven bits, and its lowest bit is always zero.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy_n is 1, rd_oe is 0, rd_data is 0, and every result register reads as zero.
- R2: busy_n stays low for exactly n×40 clock cycles. n is 2 for mode 00, 3 for mode 01, 3 for mode 10 and 4 for mode 11.
- R3: busy_n goes low on the third rising clock edge after conv_start goes high (two synchroniser flops, then the start register).
- R4: A conv_start held high starts only one conversion. A new rising edge of conv_start while busy_n is low has no effect, and busy_n stays high afterwards.
- R5: Channel codes are 0 for IN1, 1 for IN2, 2 for IN3 and 3 for AUX. Mode 00 converts {1,2}, mode 01 converts {1,2,3}, mode 10 converts {0,1,2} and mode 11 converts {0,1,2,3}. Channels are converted in ascending order, one 40-cycle slot each. conv_chan shows the active channel, and core_code is captured in the last cycle of each slot.
- R6: The result registers do not change while busy_n is low. Reads during a conversion return the previous results, and the new codes appear on the edge where busy_n returns high.
- R7: reg_addr 00/01/10/11 selects the IN1/IN2/IN3/AUX register. One cycle after a clock edge that sees cs_n=0 and rd_n=0, rd_oe is 1 and rd_data is {code[10:0], 1'b0}.
- R8: One cycle after an edge that sees cs_n=1 or rd_n=1, rd_oe is 0 and rd_data is 0.
- R9: The result registers of channels outside the selected set keep their earlier values.
- R10: mode_sel and aux_sel are latched at the start. aux_mux shows the latched auxiliary choice, and changing either input during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Asynchronous start strobe |
| mode_sel | input | 2 | Channel-set selection |
| aux_sel | input | 2 | Auxiliary input choice |
| core_code | input | 11 | Two's-complement code from the converter core |
| cs_n | input | 1 | Register port select, active low |
| rd_n | input | 1 | Register read strobe, active low |
| reg_addr | input | 2 | Result register address |
| busy_n | output | 1 | Low while a conversion sequence runs |
| hold | output | 1 | High while the inputs are held |
| conv_chan | output | 2 | Channel being converted |
| aux_mux | output | 2 | Latched auxiliary mux choice |
| rd_data | output | 12 | Read data, code in bits 11..1, bit 0 zero |
| rd_oe | output | 1 | Read data output enable |

## Verification
The assertions assume that mode_sel and aux_sel settle before the start strobe reaches the start register. They also assume that a strobe edge arriving while busy_n is low is ignored and is not queued. The stimulus changes both selects only while the block is idle, and at least three cycles before it raises conv_start. During each conversion it deliberately scrambles the selects, drops and re-raises the strobe, and reads a register, so that latching and the held old data are both exercised. The core model returns a code that depends on the conv_chan output, so the order of capture can be seen in the stored results.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NCH = 4;
  typedef logic [1:0] chan_t;

  // channel window is contiguous: upper mode bit includes IN1, lower bit includes AUX
  function automatic chan_t win_first(input logic [1:0] m);
    return m[1] ? 2'd0 : 2'd1;
  endfunction

  function automatic chan_t win_last(input logic [1:0] m);
    return m[0] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [NCH-1:0] win_mask(input logic [1:0] m);
    return {m[0], 1'b1, 1'b1, m[1]};
  endfunction
endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_slot_timer.sv
module adc_slot_timer
  import adc_seq_pkg::*;
#(
  parameter int SLOT_CYC = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_pulse,
  input  logic [1:0]     mode_sel,
  input  logic [1:0]     aux_sel,
  output logic           busy_n,
  output logic           hold,
  output chan_t          conv_chan,
  output logic [1:0]     aux_mux,
  output logic [NCH-1:0] run_mask,
  output logic           cap_en,
  output logic           commit
);
  localparam int CNT_W = $clog2(SLOT_CYC);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SLOT_CYC - 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       mode_q;

  assign run_mask = win_mask(mode_q);
  assign cap_en   = (st == ST_RUN) && (cnt == CNT_END);
  assign commit   = cap_en && (conv_chan == win_last(mode_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      mode_q    <= 2'b00;
      aux_mux   <= 2'b00;
      conv_chan <= 2'd0;
      busy_n    <= 1'b1;
      hold      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_pulse) begin
            st        <= ST_RUN;
            mode_q    <= mode_sel;
            aux_mux   <= aux_sel;
            conv_chan <= win_first(mode_sel);
            cnt       <= '0;
            busy_n    <= 1'b0;
            hold      <= 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt == CNT_END) begin
            cnt <= '0;
            if (commit) begin
              st     <= ST_IDLE;
              busy_n <= 1'b1;
              hold   <= 1'b0;
            end else begin
              conv_chan <= conv_chan + 2'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 11,
  parameter int BUS_W  = CODE_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_en,
  input  chan_t                 cap_ch,
  input  logic                  commit,
  input  logic [NCH-1:0]        run_mask,
  input  logic [CODE_W-1:0]     code_in,
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic [1:0]            addr,
  output logic [BUS_W-1:0]      rd_data,
  output logic                  rd_oe,
  output logic [NCH*CODE_W-1:0] res_flat
);
  localparam int PAD_W = BUS_W - CODE_W;

  logic [CODE_W-1:0] shadow [NCH];
  logic [CODE_W-1:0] result [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        shadow[i] <= '0;
        result[i] <= '0;
      end
    end else begin
      if (cap_en) shadow[cap_ch] <= code_in;
      if (commit) begin
        for (int i = 0; i < NCH; i++) begin
          if (run_mask[i])
            result[i] <= (cap_en && cap_ch == chan_t'(i)) ? code_in : shadow[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else if (!cs_n && !rd_n) begin
      rd_data <= {result[addr], {PAD_W{1'b0}}};
      rd_oe   <= 1'b1;
    end else begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_flat
      assign res_flat[g*CODE_W +: CODE_W] = result[g];
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOT_CYC    = 40,
  parameter int CODE_W      = 11,
  parameter int BUS_W       = CODE_W + 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic [1:0]        mode_sel,
  input  logic [1:0]        aux_sel,
  input  logic [CODE_W-1:0] core_code,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [1:0]        reg_addr,
  output logic              busy_n,
  output logic              hold,
  output logic [1:0]        conv_chan,
  output logic [1:0]        aux_mux,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_oe
);
  logic                  start_pulse;
  logic [NCH-1:0]        run_mask;
  logic                  cap_en;
  logic                  commit;
  logic [NCH*CODE_W-1:0] res_flat;

  adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(conv_start), .rise(start_pulse)
  );

  adc_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst(rst), .start_pulse(start_pulse),
    .mode_sel(mode_sel), .aux_sel(aux_sel),
    .busy_n(busy_n), .hold(hold), .conv_chan(conv_chan), .aux_mux(aux_mux),
    .run_mask(run_mask), .cap_en(cap_en), .commit(commit)
  );

  adc_result_bank #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_bank (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_ch(conv_chan),
    .commit(commit), .run_mask(run_mask), .code_in(core_code),
    .cs_n(cs_n), .rd_n(rd_n), .addr(reg_addr),
    .rd_data(rd_data), .rd_oe(rd_oe), .res_flat(res_flat)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int SLOT_CYC = 40,
  parameter int CODE_W   = 11,
  parameter int BUS_W    = CODE_W + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                busy_n,
  input logic [3:0]          run_mask,
  input logic [1:0]          conv_chan,
  input logic [1:0]          aux_mux,
  input logic                cs_n,
  input logic                rd_n,
  input logic                rd_oe,
  input logic [BUS_W-1:0]    rd_data,
  input logic [4*CODE_W-1:0] res_flat
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)          low_cnt <= '0;
    else if (busy_n)  low_cnt <= '0;
    else              low_cnt <= low_cnt + 1'b1;
  end

  // R2: busy length matches the latched channel count
  a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (low_cnt == 32'(SLOT_CYC * $countones(run_mask))));

  // R4: no immediate restart after a sequence ends
  a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |=> busy_n);

  // R5: active channel belongs to the latched set
  a_r5_chan_in_set: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> run_mask[conv_chan]);

  // R6: results frozen while busy is low
  a_r6_hold_results: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> $stable(res_flat));

  // R7: read strobe enables the bus on the next cycle, low bit zero
  a_r7_read_oe: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |=> (rd_oe && rd_data[0] == 1'b0));

  // R8: no strobe, bus disabled and quiet
  a_r8_idle_bus: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> (!rd_oe && rd_data == '0));

  // R10: aux choice frozen inside a sequence
  a_r10_aux_frozen: assert property (@(posedge clk) disable iff (rst)
    (!busy_n && $past(!busy_n)) |-> $stable(aux_mux));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .SLOT_CYC(SLOT_CYC), .CODE_W(CODE_W), .BUS_W(BUS_W)
) u_chk (
  .clk(clk), .rst(rst), .busy_n(busy_n), .run_mask(run_mask),
  .conv_chan(conv_chan), .aux_mux(aux_mux), .cs_n(cs_n), .rd_n(rd_n),
  .rd_oe(rd_oe), .rd_data(rd_data), .res_flat(res_flat)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int SLOT = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_start = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [1:0]  aux_sel = 2'b00;
  logic [10:0] core_code;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [1:0]  reg_addr = 2'b00;
  logic        busy_n, hold, rd_oe;
  logic [1:0]  conv_chan, aux_mux;
  logic [11:0] rd_data;

  logic [31:0] run_tag = 32'd0;
  logic [10:0] exp_res [4];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [10:0] mk_code(input logic [31:0] tag, input logic [1:0] ch);
    return tag[10:0] ^ {ch, 2'b01, ch, 5'b10110};
  endfunction

  function automatic logic [3:0] bmask(input logic [1:0] m);
    case (m)
      2'b00:   return 4'b0110;
      2'b01:   return 4'b1110;
      2'b10:   return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [1:0] ch_at(input logic [3:0] msk, input int slot);
    int seen = 0;
    for (int i = 0; i < 4; i++) begin
      if (msk[i]) begin
        if (seen == slot) return 2'(i);
        seen++;
      end
    end
    return 2'd0;
  endfunction

  assign core_code = mk_code(run_tag, conv_chan);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .conv_start(conv_start), .mode_sel(mode_sel),
    .aux_sel(aux_sel), .core_code(core_code), .cs_n(cs_n), .rd_n(rd_n),
    .reg_addr(reg_addr), .busy_n(busy_n), .hold(hold), .conv_chan(conv_chan),
    .aux_mux(aux_mux), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // read one register: strobe at a negedge, sample at the next
  task automatic rd_reg(input logic [1:0] a, input string req);
    reg_addr = a; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk(rd_oe === 1'b1 && rd_data === {exp_res[a], 1'b0}, req,
        int'(rd_data), int'({exp_res[a], 1'b0}));
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk(rd_oe === 1'b0 && rd_data === 12'h000, "R8 bus idle after read",
        int'({rd_oe, rd_data}), 0);
  endtask

  task automatic run_conv(input logic [1:0] m, input logic [1:0] ax, input logic [31:0] tag);
    logic [3:0] msk;
    int lat, k, n;
    bit chan_ok, aux_ok;
    logic [1:0] ra;
    msk = bmask(m);
    n = $countones(msk);
    run_tag = tag; mode_sel = m; aux_sel = ax;
    repeat (3) @(negedge clk);
    conv_start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (busy_n === 1'b1 && lat < 10);
    chk(lat == 3, "R3 start latency", lat, 3);
    k = 0; chan_ok = 1'b1; aux_ok = 1'b1;
    ra = 2'($urandom_range(0, 3));
    while (busy_n === 1'b0 && k < 400) begin
      if (conv_chan !== ch_at(msk, k / SLOT)) chan_ok = 1'b0;
      if (k == 2) conv_start = 1'b0;
      if (k == 5) begin mode_sel = ~m; aux_sel = ~ax; end
      if (k == 10) conv_start = 1'b1;
      if (k == 13) conv_start = 1'b0;
      if (k == 20) begin reg_addr = ra; cs_n = 1'b0; rd_n = 1'b0; end
      if (k == 21) begin
        chk(rd_oe === 1'b1 && rd_data === {exp_res[ra], 1'b0}, "R6 old data during busy",
            int'(rd_data), int'({exp_res[ra], 1'b0}));
        cs_n = 1'b1; rd_n = 1'b1;
      end
      if (k == 30 && aux_mux !== ax) aux_ok = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(k == n * SLOT, "R2 busy length", k, n * SLOT);
    chk(chan_ok, "R5 channel order", 0, 1);
    chk(aux_ok, "R10 aux latched", int'(aux_mux), int'(ax));
    for (int i = 0; i < 4; i++) if (msk[i]) exp_res[i] = mk_code(tag, 2'(i));
    repeat (6) @(negedge clk);
    chk(busy_n === 1'b1, "R4 no extra start", int'(busy_n), 1);
    for (int i = 0; i < 4; i++)
      rd_reg(2'(i), msk[i] ? "R7 new result" : "R9 unconverted kept");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_res[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_n === 1'b1 && rd_oe === 1'b0 && rd_data === 12'h000, "R1 reset state",
        int'({busy_n, rd_oe, rd_data}), 32'h2000);
    for (int i = 0; i < 4; i++) rd_reg(2'(i), "R1 zero result");
    // R8: select without read strobe keeps the bus off
    cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rd_oe === 1'b0 && rd_data === 12'h000, "R8 select only", int'(rd_oe), 0);
    cs_n = 1'b1;
    // directed: every mode, extreme codes
    run_conv(2'b11, 2'b10, 32'h0000_0400);
    run_conv(2'b00, 2'b01, 32'h0000_03FF);
    run_conv(2'b01, 2'b11, 32'h0000_0000);
    run_conv(2'b10, 2'b00, 32'h0000_07FF);
    for (int r = 0; r < 30; r++)
      run_conv(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule